// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block collects message-signalled interrupts. A device raises one of 256 vectors by writing that vector's number, as a 32-bit data value, into a single shared doorbell register. The block decodes the number and latches it as a pending event. The events are held in eight 32-bit pending words, and a matching set of eight enable words selects which vectors can interrupt. Any pending vector whose enable is set drives one level-sensitive interrupt line to a parent controller.

Software reaches the block through a plain 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. There is no back-pressure: every access completes in the cycle it is presented, and read data appears one cycle after the read strobe. The handler reads the pending words and acknowledges events by writing ones to them. It sets or clears enables by read-modify-write of the enable words.

Top module: `msi_doorbell_agg`

## Requirements
- R1: After reset, every pending word and every enable word reads as zero, and `irq_out` is low.
- R2: A write to byte address 0x7C with a data value n from 0 to 255 sets bit (n mod 32) of the pending word at 0x80 + 4*(n/32), on the clock edge of the write. All other pending bits are unchanged.
- R3: A doorbell write whose 32-bit data value is 256 or above changes no pending bit, even if its low eight bits name a valid vector.
- R4: A write to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R5: The enable words at 0xA0 + 4*k (k = 0..7) are read/write registers. Bit (n mod 32) of word n/32 enables vector n.
- R6: `irq_out` is registered. It is high exactly one clock after some vector is both pending and enabled, and low one clock after no vector is.
- R7: A vector latches as pending while it is disabled, without raising `irq_out`. It raises `irq_out` once it is enabled.
- R8: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds otherwise. Reads of the doorbell, of unmapped addresses and of addresses not aligned to a word return zero.
- R9: Vectors are edge-style. Repeated doorbell writes of a vector that is already pending leave one pending bit, and one acknowledgement removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (the vector number for doorbell writes) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Level interrupt toward the parent controller |

## Verification
The main sweep rings the doorbell for each of the 256 vectors in turn. It reads back the target pending word and a neighbouring word, and this tells apart a wrong bit position from a wrong word select. Each vector is then enabled, acknowledged with an inverted mask and acknowledged with its own bit. This separates write-one-to-clear from plain write behaviour, and it shows that the interrupt follows only the pending-and-enabled pair. Directed patterns cover doorbell values with valid low bits but a large full value, repeated rings of one vector, distinct enable patterns per word, and reads of the doorbell, of misaligned addresses and of unmapped addresses. One check samples the interrupt in the half cycle before its register updates and again after, which pins down its one-cycle delay.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  typedef enum logic [1:0] {
    REG_NONE     = 2'd0,
    REG_DOORBELL = 2'd1,
    REG_PENDING  = 2'd2,
    REG_ENABLE   = 2'd3
  } msi_region_e;
endpackage

// File: rtl/msi_bus_decode.sv
module msi_bus_decode
  import msi_agg_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DB_OFS    = 'h7C,
  parameter int PEND_BASE = 'h80,
  parameter int EN_BASE   = 'hA0
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               wr,
  input  logic [WORD_W-1:0]                  wdata,
  output msi_region_e                        region,
  output logic [((NUM_VEC/WORD_W)>1 ? $clog2(NUM_VEC/WORD_W) : 1)-1:0] word_idx,
  output logic [NUM_VEC-1:0]                 set_vec,
  output logic [NUM_VEC/WORD_W-1:0]          clr_sel,
  output logic [NUM_VEC/WORD_W-1:0]          en_sel
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int PEND_WD   = PEND_BASE / 4;
  localparam int EN_WD     = EN_BASE / 4;

  logic [31:0] addr_ext;
  logic [29:0] wd;
  logic        aligned;

  assign addr_ext = 32'(addr);
  assign wd       = addr_ext[31:2];
  assign aligned  = (addr_ext[1:0] == 2'b00);

  always_comb begin
    region   = REG_NONE;
    word_idx = '0;
    if (aligned) begin
      if (addr_ext == 32'(DB_OFS)) begin
        region = REG_DOORBELL;
      end else if (wd >= 30'(PEND_WD) && wd < 30'(PEND_WD + NUM_WORDS)) begin
        region   = REG_PENDING;
        word_idx = IDX_W'(wd - 30'(PEND_WD));
      end else if (wd >= 30'(EN_WD) && wd < 30'(EN_WD + NUM_WORDS)) begin
        region   = REG_ENABLE;
        word_idx = IDX_W'(wd - 30'(EN_WD));
      end
    end
  end

  // Doorbell: one-hot set of the named vector, out-of-range values dropped.
  always_comb begin
    set_vec = '0;
    if (wr && region == REG_DOORBELL && wdata < WORD_W'(NUM_VEC))
      set_vec[wdata[VEC_W-1:0]] = 1'b1;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
    assign clr_sel[w] = wr && (region == REG_PENDING) && (word_idx == IDX_W'(w));
    assign en_sel[w]  = wr && (region == REG_ENABLE)  && (word_idx == IDX_W'(w));
  end
endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_bits,
  input  logic [WORD_W-1:0] clr_bits,
  input  logic              en_we,
  input  logic [WORD_W-1:0] en_wdata,
  output logic [WORD_W-1:0] pending,
  output logic [WORD_W-1:0] enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enable  <= '0;
    end else begin
      pending <= (pending & ~clr_bits) | set_bits;
      if (en_we) enable <= en_wdata;
    end
  end

  // R2 / R4: a doorbell set always lands, even against a same-cycle clear.
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((pending & $past(set_bits)) == $past(set_bits)));

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((pending & $past(clr_bits & ~set_bits)) == '0));

  p_pending_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> (pending == $past(pending)));

  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (enable == $past(en_wdata)));

  p_enable_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(enable));
endmodule

// File: rtl/msi_irq_reduce.sv
module msi_irq_reduce #(
  parameter int NUM_VEC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pending,
  input  logic [NUM_VEC-1:0] enable,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(pending & enable);
  end

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & enable)) |=> irq);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pending & enable)) |=> !irq);
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg
  import msi_agg_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DB_OFS    = 'h7C,
  parameter int PEND_BASE = 'h80,
  parameter int EN_BASE   = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  msi_region_e           region;
  logic [IDX_W-1:0]      word_idx;
  logic [NUM_VEC-1:0]    set_vec;
  logic [NUM_WORDS-1:0]  clr_sel;
  logic [NUM_WORDS-1:0]  en_sel;
  logic [WORD_W-1:0]     pend_w [NUM_WORDS];
  logic [WORD_W-1:0]     en_w   [NUM_WORDS];
  logic [NUM_VEC-1:0]    pend_flat;
  logic [NUM_VEC-1:0]    en_flat;

  msi_bus_decode #(
    .NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .DB_OFS(DB_OFS), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE)
  ) u_decode (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .region   (region),
    .word_idx (word_idx),
    .set_vec  (set_vec),
    .clr_sel  (clr_sel),
    .en_sel   (en_sel)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
    msi_vector_bank #(.WORD_W(WORD_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_vec[w*WORD_W +: WORD_W]),
      .clr_bits (clr_sel[w] ? bus_wdata : '0),
      .en_we    (en_sel[w]),
      .en_wdata (bus_wdata),
      .pending  (pend_w[w]),
      .enable   (en_w[w])
    );
    assign pend_flat[w*WORD_W +: WORD_W] = pend_w[w];
    assign en_flat[w*WORD_W +: WORD_W]   = en_w[w];
  end

  msi_irq_reduce #(.NUM_VEC(NUM_VEC)) u_reduce (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pend_flat),
    .enable  (en_flat),
    .irq     (irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (region)
        REG_PENDING: bus_rdata <= pend_w[word_idx];
        REG_ENABLE:  bus_rdata <= en_w[word_idx];
        default:     bus_rdata <= '0;
      endcase
    end
  end

  p_db_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(DB_OFS)) |=> (bus_rdata == '0));

  p_rdata_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_one_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: tb/msi_doorbell_agg_bench.sv
module msi_doorbell_agg_bench;
  localparam int NV = 256;
  localparam int NW = 8;
  localparam logic [7:0] A_DB = 8'h7C;
  localparam logic [7:0] A_PD = 8'h80;
  localparam logic [7:0] A_EN = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_doorbell_agg u_msi_doorbell_agg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    chk(req, 32'(irq_out), 32'(exp));
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", 32'(irq_out), 32'h0);
    for (int w = 0; w < NW; w++) begin
      bread(A_PD + 8'(4*w), rd); chk("R1 pending", rd, 32'h0);
      bread(A_EN + 8'(4*w), rd); chk("R1 enable", rd, 32'h0);
    end

    // R3: out-of-range doorbell values
    bwrite(A_DB, 32'h100);
    bwrite(A_DB, 32'h1FF);
    bwrite(A_DB, 32'hFFFF_FFFF);
    bwrite(A_DB, 32'h8000_0005);
    for (int w = 0; w < NW; w++) begin
      bread(A_PD + 8'(4*w), rd); chk("R3 ignored", rd, 32'h0);
    end

    // R8: doorbell, unmapped and misaligned reads
    bwrite(A_EN, 32'hFFFF_FFFF);
    bwrite(A_DB, 32'd3);
    bread(A_DB, rd);  chk("R8 doorbell read", rd, 32'h0);
    bread(8'h00, rd); chk("R8 unmapped 0x00", rd, 32'h0);
    bread(8'h40, rd); chk("R8 unmapped 0x40", rd, 32'h0);
    bread(8'hC0, rd); chk("R8 unmapped 0xC0", rd, 32'h0);
    bread(8'h81, rd); chk("R8 misaligned pend", rd, 32'h0);
    bread(8'hA2, rd); chk("R8 misaligned en", rd, 32'h0);
    @(negedge clk);
    chk("R8 rdata holds", bus_rdata, 32'h0);
    bread(A_PD, rd);  chk("R8 pending read", rd, 32'h8);
    repeat (2) @(negedge clk);
    chk("R8 rdata holds after", bus_rdata, 32'h8);
    bwrite(A_PD, 32'h8);
    bwrite(A_EN, 32'h0);

    // R5: enable read/write patterns
    for (int w = 0; w < NW; w++)
      bwrite(A_EN + 8'(4*w), (32'h1111_1111 * 32'(w)) ^ 32'hA5A5_5A5A);
    for (int w = 0; w < NW; w++) begin
      bread(A_EN + 8'(4*w), rd);
      chk("R5 enable readback", rd, (32'h1111_1111 * 32'(w)) ^ 32'hA5A5_5A5A);
    end
    for (int w = 0; w < NW; w++) bwrite(A_EN + 8'(4*w), 32'h0);
    chk_irq("R5 irq off", 1'b0);

    // R9: repeated rings of one vector
    bwrite(A_DB, 32'd40);
    bwrite(A_DB, 32'd40);
    bwrite(A_DB, 32'd40);
    bread(A_PD + 8'h4, rd); chk("R9 one bit", rd, 32'h100);
    bwrite(A_PD + 8'h4, 32'h100);
    bread(A_PD + 8'h4, rd); chk("R9 one ack", rd, 32'h0);

    // R6: exact one-cycle delay of irq_out
    bwrite(A_DB, 32'd200);
    bwrite(A_EN + 8'h18, 32'h100);
    chk("R6 irq not yet", 32'(irq_out), 32'h0);
    chk_irq("R6 irq one cycle", 1'b1);
    bwrite(A_PD + 8'h18, 32'h100);
    chk("R6 irq still high", 32'(irq_out), 32'h1);
    chk_irq("R6 irq drops", 1'b0);
    bwrite(A_EN + 8'h18, 32'h0);

    // R2/R4/R6/R7: sweep over every vector
    for (int v = 0; v < NV; v++) begin
      int w;
      logic [31:0] m;
      w = v / 32;
      m = 32'h1 << (v % 32);
      bwrite(A_DB, 32'(v));
      bread(A_PD + 8'(4*w), rd);            chk("R2 set bit", rd, m);
      bread(A_PD + 8'(4*((w+1)%NW)), rd);   chk("R2 other word", rd, 32'h0);
      chk_irq("R7 disabled quiet", 1'b0);
      bwrite(A_EN + 8'(4*w), m);
      chk_irq("R7 enable raises", 1'b1);
      bwrite(A_PD + 8'(4*w), ~m);
      bread(A_PD + 8'(4*w), rd);            chk("R4 zeros keep", rd, m);
      bwrite(A_PD + 8'(4*w), m);
      bread(A_PD + 8'(4*w), rd);            chk("R4 ones clear", rd, 32'h0);
      chk("R6 irq cleared", 32'(irq_out), 32'h0);
      bwrite(A_EN + 8'(4*w), 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule